// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit memory-mapped register that records why the system last came out of reset and lets software ask for a new one. Five bits at the top of the word are defined. Bit 31 marks a cold start. Bits 28 and 27 are cause flags for push-button resets, and software clears them by writing one. Bits 30 and 29 are request bits. Writing a one to bit 30 asks for a cold soft reset. Writing a one to bit 29 alone asks for a warm soft reset. Every other bit reads as zero.

The block tells the first system reset after power-up apart from later ones by keeping a small saturating count of system resets. The count itself is cleared only by the power-up reset `rst_ni`. The reset controller pulses `sys_rst_i` once for each system reset. On the first such pulse the register is loaded with only bit 31 set. Later pulses leave the register as it is. A cold soft request also clears the count, so the next system reset is again treated as a cold start.

Requests leave the block as a one-cycle pulse on `rst_req_o` with a cause flag on `rst_cause_o`. The block only raises the request. It does not reset any other logic.

Top module: `rstc_cause_reg`

## Requirements
- R1: While `rst_ni` is low and after it rises, the register reads 0x00000000, `rst_req_o` is 0, and the reset count is zero, so the next `sys_rst_i` is treated as the first.
- R2: The register is read through `rdata_o` when `addr_i` bits 15..3 equal 0xF020 >> 3 and `addr_i` bit 2 is 1 (for example 0xF024). Address 0xF020 (bit 2 = 0) and every other address read 0.
- R3: Bits 31, 28 and 27 are write-one-to-clear. Writing a 0 to any of them leaves it unchanged.
- R4: Writing a 1 to bit 30 or bit 29 sets that bit. Writing a 0 to it leaves the bit as it was.
- R5: Bits 26..0 are masked off on write and always read 0.
- R6: A write with bit 30 = 1 raises `rst_req_o` in the cycle after the write, with `rst_cause_o` = 0 (cold). It also clears the reset count, so the next `sys_rst_i` loads 0x80000000.
- R7: A write with bit 29 = 1 and bit 30 = 0 raises `rst_req_o` with `rst_cause_o` = 1 (warm). The reset count is left unchanged.
- R8: A write with both bit 30 and bit 29 set gives `rst_cause_o` = 0.
- R9: A `sys_rst_i` cycle while the count is zero loads the register with exactly 0x80000000. A `sys_rst_i` cycle while the count is non-zero leaves the register unchanged. Every `sys_rst_i` cycle increments the count.
- R10: The count saturates at 2^CNT_W-1 and never wraps. Any number of further system resets leaves the register unchanged.
- R11: A write to any address other than the register word changes nothing and raises no request.
- R12: A write in the same cycle as `sys_rst_i` is dropped: the register follows R9 only and no request is raised.
- R13: `rst_req_o` is never high for two cycles in a row. A trigger written in the cycle right after a request was issued raises no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| sys_rst_i | input | 1 | One-cycle indication that a system reset took place |
| addr_i | input | 16 | Byte address within the block |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle soft reset request |
| rst_cause_o | output | 1 | Request cause: 0 = cold, 1 = warm |

## Verification
A register write and a `sys_rst_i` event can arrive in the same clock cycle. The bench provokes this by raising both for one edge with a cold trigger in the write data. It then judges the result by three things: no request pulse follows, the register shows only the R9 outcome, and the reset count still behaves as untouched on the next system reset. A second collision happens when a trigger write lands in the cycle right after a request pulse, and the bench checks that no second pulse appears.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam logic [31:0] IMPL_MASK     = 32'hF800_0000;
  localparam logic [31:0] W1C_MASK      = 32'h9800_0000;
  localparam logic [31:0] SET_MASK      = 32'h6000_0000;
  localparam logic [31:0] COLD_VAL      = 32'h8000_0000;
  localparam int unsigned BIT_SOFT_COLD = 30;
  localparam int unsigned BIT_SOFT_WARM = 29;

  typedef enum logic {
    CAUSE_COLD = 1'b0,
    CAUSE_WARM = 1'b1
  } req_cause_e;
endpackage

// File: rtl/rstc_decode.sv
module rstc_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-4:0] BASE_WORD = BASE_ADDR[ADDR_W-1:3];

  logic [1:0] unused_lane;
  assign unused_lane = addr_i[1:0];

  // data lives in the upper word of the 8-byte window
  assign hit_o = (addr_i[ADDR_W-1:3] == BASE_WORD) && addr_i[2];
endmodule

// File: rtl/rstc_boot_cnt.sv
module rstc_boot_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic clr_i,
  output logic zero_o,
  output logic sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign sat_o  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              first_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              req_o,
  output logic              cause_o,
  output logic              cnt_clr_o
);
  logic [DATA_W-1:0] stat_q, stat_d, wmask;
  logic              req_q, cause_q, trig, fire;

  assign wmask  = wdata_i & IMPL_MASK;
  assign stat_d = (stat_q & ~(wmask & W1C_MASK)) | (wmask & SET_MASK);
  assign trig   = wr_i && (wmask[BIT_SOFT_COLD] || wmask[BIT_SOFT_WARM]);
  assign fire   = trig && !req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (sys_rst_i) begin
      if (first_i) stat_q <= COLD_VAL;
    end else if (wr_i) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_COLD;
    end else begin
      req_q <= fire;
      if (fire) cause_q <= wmask[BIT_SOFT_COLD] ? CAUSE_COLD : CAUSE_WARM;
    end
  end

  assign stat_o    = stat_q;
  assign req_o     = req_q;
  assign cause_o   = cause_q;
  assign cnt_clr_o = wr_i && wmask[BIT_SOFT_COLD];
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              rst_cause_o
);
  logic              addr_hit, wr_en, cnt_zero, cnt_sat, cnt_clr;
  logic [DATA_W-1:0] stat_q;

  rstc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (addr_hit)
  );

  // system reset wins over a colliding bus write
  assign wr_en = we_i && addr_hit && !sys_rst_i;

  rstc_boot_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sys_rst_i),
    .clr_i  (cnt_clr),
    .zero_o (cnt_zero),
    .sat_o  (cnt_sat)
  );

  rstc_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .first_i   (cnt_zero),
    .wr_i      (wr_en),
    .wdata_i   (wdata_i),
    .stat_o    (stat_q),
    .req_o     (rst_req_o),
    .cause_o   (rst_cause_o),
    .cnt_clr_o (cnt_clr)
  );

  assign rdata_o = addr_hit ? stat_q : '0;
endmodule

// File: rtl/rstc_cause_reg_chk.sv
module rstc_cause_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sys_rst_i,
  input logic        we_i,
  input logic        hit_i,
  input logic        wcold_i,
  input logic        wwarm_i,
  input logic [31:0] stat_i,
  input logic        first_i,
  input logic        sat_i,
  input logic        rst_req_o,
  input logic        rst_cause_o
);
  p_impl_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[26:0] == 27'd0);

  p_sticky_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[30] && !sys_rst_i |=> stat_i[30]);

  p_cold_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && hit_i && !sys_rst_i && wcold_i && !rst_req_o |=> rst_req_o && !rst_cause_o);

  p_warm_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && hit_i && !sys_rst_i && wwarm_i && !wcold_i && !rst_req_o |=> rst_req_o && rst_cause_o);

  p_first_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && first_i |=> stat_i == 32'h8000_0000);

  p_later_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && !first_i |=> $stable(stat_i));

  p_no_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_i && sys_rst_i |=> sat_i);

  p_stray_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !hit_i && !sys_rst_i |=> $stable(stat_i) && !rst_req_o);

  p_collide_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> !rst_req_o);

  p_one_shot_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

bind rstc_cause_reg rstc_cause_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sys_rst_i   (sys_rst_i),
  .we_i        (we_i),
  .hit_i       (addr_hit),
  .wcold_i     (wdata_i[30]),
  .wwarm_i     (wdata_i[29]),
  .stat_i      (stat_q),
  .first_i     (cnt_zero),
  .sat_i       (cnt_sat),
  .rst_req_o   (rst_req_o),
  .rst_cause_o (rst_cause_o)
);

// File: tb/rstc_cause_reg_tb.sv
module rstc_cause_reg_tb;
  localparam logic [15:0] REG_ADDR = 16'hF024;
  localparam int          CNT_MAX  = 15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic [15:0] addr_i = REG_ADDR;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o, rst_cause_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_reg = '0;
  int          m_cnt = 0;

  always #2 clk_i = ~clk_i;

  rstc_cause_reg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rst_req_o(rst_req_o), .rst_cause_o(rst_cause_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req);
    addr_i = REG_ADDR;
    #1;
    chk(req, rdata_o, m_reg);
  endtask

  task automatic power_up();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_reg = '0;
    m_cnt = 0;
  endtask

  task automatic sys_reset();
    @(negedge clk_i);
    sys_rst_i = 1'b1;
    @(negedge clk_i);
    sys_rst_i = 1'b0;
    if (m_cnt == 0) m_reg = 32'h8000_0000;
    if (m_cnt < CNT_MAX) m_cnt++;
  endtask

  function automatic logic is_hit(input logic [15:0] a);
    return (a[15:3] == REG_ADDR[15:3]) && a[2];
  endfunction

  // one-cycle write from idle, then checks on request, cause and single pulse
  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string req);
    logic [31:0] m;
    logic        exp_req;
    m = d & 32'hF800_0000;
    exp_req = is_hit(a) && (m[30] || m[29]);
    if (is_hit(a)) begin
      m_reg = (m_reg & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000);
      if (m[30]) m_cnt = 0;
    end
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk({req, " req"}, {31'd0, rst_req_o}, {31'd0, exp_req});
    if (exp_req) chk({req, " cause"}, {31'd0, rst_cause_o}, {31'd0, !m[30]});
    @(negedge clk_i);
    chk("R13 pulse width", {31'd0, rst_req_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 during and after power-up reset
    #1;
    chk("R1 rdata in reset", rdata_o, 32'd0);
    chk("R1 req in reset", {31'd0, rst_req_o}, 32'd0);

    // sweep all combinations of the five defined bits (R3 R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < 32; v++) begin
      logic [31:0] d;
      d = {v[4:0], (v % 2 == 1) ? 27'h7FF_FFFF : 27'h2AA_AAAA};
      power_up();
      chk_reg("R1 after reset");
      sys_reset();
      chk_reg("R9 first load");
      wr(REG_ADDR, d, (d[30] ? "R6 R8" : (d[29] ? "R7" : "R3")));
      chk_reg("R3 R4 R5 write");
      sys_reset();
      chk_reg(d[30] ? "R6 reload" : "R9 hold");
    end

    // R2 decode of other words
    power_up();
    sys_reset();
    addr_i = 16'hF020; #1;
    chk("R2 low word", rdata_o, 32'd0);
    addr_i = 16'h1004; #1;
    chk("R2 other addr", rdata_o, 32'd0);
    chk_reg("R2 reg word");

    // R11 stray writes
    wr(16'hF020, 32'hFFFF_FFFF, "R11 low word");
    chk_reg("R11 low word");
    wr(16'hF02C, 32'hFFFF_FFFF, "R11 next word");
    chk_reg("R11 next word");

    // R4 write zero keeps set bits
    wr(REG_ADDR, 32'h2000_0000, "R7");
    wr(REG_ADDR, 32'h0000_0000, "R4");
    chk_reg("R4 zero keeps");

    // R10 saturation: 20 system resets must never reload
    for (int i = 0; i < 20; i++) sys_reset();
    chk_reg("R10 no wrap");
    chk("R10 value", rdata_o, 32'hA000_0000);

    // R6 cold request clears count, next reset reloads
    wr(REG_ADDR, 32'h4000_0000, "R6");
    sys_reset();
    chk_reg("R6 reload after cold");
    chk("R6 value", rdata_o, 32'h8000_0000);

    // R13 back-to-back triggers: second pulse suppressed
    @(negedge clk_i);
    addr_i = REG_ADDR; wdata_i = 32'h2000_0000; we_i = 1'b1;
    @(negedge clk_i);
    chk("R13 first pulse", {31'd0, rst_req_o}, 32'd1);
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R13 second suppressed", {31'd0, rst_req_o}, 32'd0);
    m_reg = m_reg | 32'h2000_0000;
    chk_reg("R13 reg");

    // R12 write colliding with system reset
    power_up();
    @(negedge clk_i);
    addr_i = REG_ADDR; wdata_i = 32'h4000_0000; we_i = 1'b1; sys_rst_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; sys_rst_i = 1'b0;
    m_reg = 32'h8000_0000; m_cnt = 1;
    chk("R12 no req", {31'd0, rst_req_o}, 32'd0);
    chk_reg("R12 reg");
    sys_reset();
    chk_reg("R12 count kept");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule